// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the memory-mapped register side of a high-precision event timer with a parameterised number of timer channels (eight by default). It decodes 32-bit and 64-bit register accesses, holds the fixed capability word, the general configuration word and the level-interrupt status word, and runs a 32-bit main counter that advances on an external tick enable while the timer is enabled.

The channels' comparator logic sits outside. The block hands each channel its access strobes, an aligned write word with a byte-lane mask, and a selector that picks the channel register. It takes back the addressed channel's read word and the channels' level-interrupt set requests. It broadcasts the enable state, the counter value and a one-cycle restart pulse. Channels use the restart pulse to recompute their next expiry whenever counting resumes or the counter is rewritten while running.

Register offsets: capability 0x000, configuration 0x010 (bit 0 enable, bit 1 legacy routing, never stored), status 0x020, main counter 0x0F0. Channel n occupies 0x100 + 0x20·n, with its configuration at +0x00, its comparator at +0x08 and its message word at +0x10.

Top module: `evt_regfront`

## Requirements
- R1: Only accesses with `acc_size` equal to 4 or 8 whose address is a multiple of that size are accepted. Any other write changes no register and raises no channel strobe. Any other read loads 0 into `rdata`.
- R2: A 4-byte access with address bit 2 set addresses bits 63:32 of the 64-bit register: write data bits 31:0 land in bits 63:32 and only that half changes. A 4-byte read returns the addressed half in `rdata[31:0]` with `rdata[63:32]` zero. An 8-byte read returns the whole word.
- R3: The capability word is read-only. It reads 0x05F5E100_A5C30701 with default parameters: tick period in femtoseconds in bits 63:32, vendor code in 31:16, counter-size bit 13 clear, channel count minus one in 12:8, revision 1 in 7:0.
- R4: The configuration word keeps every written bit except bit 1, which always reads 0.
- R5: The main counter increments by one on each clock edge where `cnt_en` (configuration bit 0) and `tick_en` are both 1. While `cnt_en` is 0 it holds its value.
- R6: `cnt_restart` pulses for one cycle, in the cycle after a configuration write that changes the enable bit from 0 to 1. A write that clears the enable bit, or leaves it unchanged, gives no pulse.
- R7: A counter write zero-extends the counter to 64 bits, merges the written half or whole word, and keeps the low 32 bits. An upper-half write therefore leaves the counter unchanged. If the counter is enabled, the write also produces the `cnt_restart` pulse in the following cycle.
- R8: Status bit n is set when `ch_irq_set[n]` is 1 and stays set until cleared. A status write clears only bits that are both set and written as 1, and `irq_clr` shows those bits during the write cycle. A set request in the same cycle as a clear wins.
- R9: A read of an unmapped offset returns 0. This covers channel indexes at or above the channel count and sub-offset 0x18 within a channel.
- R10: An accepted access to a channel register raises the one-hot `ch_wr` or `ch_rd` bit of that channel in the same cycle. `ch_reg` is address bits 4:3, and `ch_wdata`/`ch_wmask` carry the half-aligned data and mask of R2. A read returns `ch_rdata` under the R2 half rules.
- R11: After reset, configuration, status, counter, `rdata` and `cnt_restart` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | AW | Byte offset of the access |
| acc_size | input | 4 | Access size in bytes |
| wdata | input | 64 | Write data, right-aligned for 4-byte accesses |
| rdata | output | 64 | Registered read data, valid the cycle after `rd_stb` |
| tick_en | input | 1 | Counter tick enable |
| cnt_en | output | 1 | Timer enabled (configuration bit 0) |
| cnt_val | output | 32 | Main counter value |
| cnt_restart | output | 1 | One-cycle pulse: channels recompute expiry |
| ch_wr | output | NCH | One-hot channel write strobe |
| ch_rd | output | NCH | One-hot channel read strobe |
| ch_reg | output | 2 | Channel register select (0 config, 1 comparator, 2 message) |
| ch_wdata | output | 64 | Half-aligned write data for channels |
| ch_wmask | output | 64 | Bit mask of the written half |
| ch_rdata | input | 64 | Read word of the addressed channel register |
| ch_irq_set | input | NCH | Level-interrupt set requests from channels |
| irq_level | output | NCH | Status word: level interrupts asserted |
| irq_clr | output | NCH | Status bits being cleared this cycle |

## Verification
The checker watches, on every cycle, the counter's increment and hold rules, the one-hot form of the channel strobes, that a restart pulse only occurs while enabled, that set requests reach the status word and that cleared bits drop, and that an odd-sized read returns zero. Merging a half into the counter, the exact capability value, the legacy bit forced to zero, misaligned writes being dropped, and the difference between a real enable edge and a rewrite of the same value depend on specific access sequences. Only the bench's directed scenarios can show them, by reading the registers back through the bus.

// File: rtl/evt_pkg.sv
// Shared types and constants of the event timer register front end.
// Assumes byte offsets; the channel array starts at CH_BASE with CH_STRIDE
// bytes per channel.
package evt_pkg;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_CAP  = 3'd1,
        RG_CFG  = 3'd2,
        RG_STS  = 3'd3,
        RG_CNT  = 3'd4,
        RG_CHAN = 3'd5
    } region_e;

    localparam int unsigned OFS_CAP   = 'h000;
    localparam int unsigned OFS_CFG   = 'h010;
    localparam int unsigned OFS_STS   = 'h020;
    localparam int unsigned OFS_CNT   = 'h0F0;
    localparam int unsigned CH_BASE   = 'h100;
    localparam int unsigned CH_STRIDE = 'h020;

    localparam int unsigned CFG_EN_BIT  = 0;
    localparam int unsigned CFG_LEG_BIT = 1;

endpackage

// File: rtl/evt_acc_decode.sv
// Access decoder: checks size and alignment, selects the register region,
// the channel and its sub-register, and aligns write data and mask to the
// addressed 32-bit half. Purely combinational.
// Assumes AW is wide enough to hold CH_BASE + NCH*CH_STRIDE and NCH <= 32.
module evt_acc_decode
    import evt_pkg::*;
#(
    parameter int AW  = 12,
    parameter int NCH = 8
) (
    input  logic [AW-1:0]  addr,
    input  logic [3:0]     acc_size,
    input  logic [63:0]    wdata,
    output logic           acc_ok,
    output logic           acc_hi,
    output logic           acc_wide,
    output region_e        rg,
    output logic [NCH-1:0] ch_hot,
    output logic [1:0]     ch_reg,
    output logic [63:0]    wmask,
    output logic [63:0]    wdata_al
);
    localparam int IW = AW - 5;
    localparam logic [AW-1:0] A_CAP = AW'(OFS_CAP);
    localparam logic [AW-1:0] A_CFG = AW'(OFS_CFG);
    localparam logic [AW-1:0] A_STS = AW'(OFS_STS);
    localparam logic [AW-1:0] A_CNT = AW'(OFS_CNT);
    localparam logic [AW-1:0] A_CHB = AW'(CH_BASE);

    logic          sz4, sz8, aligned, in_ch;
    logic [AW-1:0] base;
    logic [IW-1:0] ch_idx;

    // Size, alignment and half selection.
    always_comb begin
        sz4      = (acc_size == 4'd4);
        sz8      = (acc_size == 4'd8);
        aligned  = sz8 ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
        acc_ok   = (sz4 || sz8) && aligned;
        acc_wide = sz8;
        acc_hi   = sz4 && addr[2];
    end

    // Region decode on the 8-byte register base.
    always_comb begin
        base   = {addr[AW-1:3], 3'b000};
        ch_idx = base[AW-1:5] - A_CHB[AW-1:5];
        in_ch  = (base >= A_CHB) && (ch_idx < IW'(NCH)) && (addr[4:3] != 2'b11);
        ch_reg = addr[4:3];
        if      (base == A_CAP) rg = RG_CAP;
        else if (base == A_CFG) rg = RG_CFG;
        else if (base == A_STS) rg = RG_STS;
        else if (base == A_CNT) rg = RG_CNT;
        else if (in_ch)         rg = RG_CHAN;
        else                    rg = RG_NONE;
    end

    // One-hot channel select, one comparator per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_hot
        assign ch_hot[g] = (rg == RG_CHAN) && (ch_idx == IW'(g));
    end

    // Write mask and data aligned to the addressed half.
    always_comb begin
        if (sz8) begin
            wmask    = '1;
            wdata_al = wdata;
        end else if (acc_hi) begin
            wmask    = {32'hFFFF_FFFF, 32'h0};
            wdata_al = {wdata[31:0], 32'h0};
        end else begin
            wmask    = {32'h0, 32'hFFFF_FFFF};
            wdata_al = wdata;
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
// Main counter: loads a merged value on a counter write, otherwise adds one
// when running and ticked. Load has priority over counting.
module evt_main_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt
);
    // Counter register with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (ld)          cnt <= ld_val;
        else if (run && tick) cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/evt_irq_status.sv
// Level-interrupt status word: one sticky bit per channel, set by the
// channel, cleared by a write of one. A set request beats a clear.
module evt_irq_status #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_req,
    input  logic [NCH-1:0] clr_req,
    output logic [NCH-1:0] level,
    output logic [NCH-1:0] clr_hit
);
    for (genvar g = 0; g < NCH; g++) begin : g_bit
        // Clear is reported only for bits that are currently set.
        assign clr_hit[g] = level[g] && clr_req[g];

        // Sticky status bit.
        always_ff @(posedge clk) begin
            if (!rst_n)          level[g] <= 1'b0;
            else if (set_req[g]) level[g] <= 1'b1;
            else if (clr_hit[g]) level[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/evt_regfront.sv
// Event timer register front end: decodes register accesses, holds the
// capability, configuration and status words and the main counter, and
// forwards channel register accesses to the external channel array.
// Assumes single-cycle strobes, never both in one cycle, and a channel array
// that returns ch_rdata combinationally for the addressed register.
module evt_regfront
    import evt_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          NCH       = 8,
    parameter logic [15:0] VENDOR    = 16'hA5C3,
    parameter logic [31:0] PERIOD_FS = 32'd100_000_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_stb,
    input  logic           rd_stb,
    input  logic [AW-1:0]  addr,
    input  logic [3:0]     acc_size,
    input  logic [63:0]    wdata,
    output logic [63:0]    rdata,
    input  logic           tick_en,
    output logic           cnt_en,
    output logic [31:0]    cnt_val,
    output logic           cnt_restart,
    output logic [NCH-1:0] ch_wr,
    output logic [NCH-1:0] ch_rd,
    output logic [1:0]     ch_reg,
    output logic [63:0]    ch_wdata,
    output logic [63:0]    ch_wmask,
    input  logic [63:0]    ch_rdata,
    input  logic [NCH-1:0] ch_irq_set,
    output logic [NCH-1:0] irq_level,
    output logic [NCH-1:0] irq_clr
);
    localparam logic [63:0] CAP_WORD =
        {PERIOD_FS, VENDOR, 3'b000, 5'(NCH - 1), 8'h01};
    localparam logic [63:0] LEG_MASK = 64'(1) << CFG_LEG_BIT;

    logic           dec_ok, dec_hi, dec_wide;
    region_e        dec_rg;
    logic [NCH-1:0] dec_ch, clr_req;
    logic [63:0]    wmask, wal, cfg_q, cfg_nx, rd_raw, rd_word;
    logic           wr_go, rd_go, cnt_ld, en_rise;
    logic [31:0]    cnt_q, cnt_ld_val;

    evt_acc_decode #(.AW(AW), .NCH(NCH)) u_dec (
        .addr     (addr),
        .acc_size (acc_size),
        .wdata    (wdata),
        .acc_ok   (dec_ok),
        .acc_hi   (dec_hi),
        .acc_wide (dec_wide),
        .rg       (dec_rg),
        .ch_hot   (dec_ch),
        .ch_reg   (ch_reg),
        .wmask    (wmask),
        .wdata_al (wal)
    );

    // Accepted strobes and derived write controls.
    always_comb begin
        wr_go      = wr_stb && dec_ok;
        rd_go      = rd_stb && dec_ok;
        cfg_nx     = ((cfg_q & ~wmask) | (wal & wmask)) & ~LEG_MASK;
        en_rise    = !cfg_q[CFG_EN_BIT] && cfg_nx[CFG_EN_BIT];
        cnt_ld     = wr_go && (dec_rg == RG_CNT);
        cnt_ld_val = (cnt_q & ~wmask[31:0]) | (wal[31:0] & wmask[31:0]);
        clr_req    = (wr_go && dec_rg == RG_STS) ? (wal[NCH-1:0] & wmask[NCH-1:0]) : '0;
    end

    // Configuration word; the legacy routing bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cfg_q <= '0;
        else if (wr_go && dec_rg == RG_CFG) cfg_q <= cfg_nx;
    end

    // Restart pulse on an enable edge or a counter rewrite while running.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_restart <= 1'b0;
        else        cnt_restart <= wr_go && ((dec_rg == RG_CFG && en_rise) ||
                                             (dec_rg == RG_CNT && cfg_q[CFG_EN_BIT]));
    end

    evt_main_counter #(.CW(32)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_q[CFG_EN_BIT]),
        .tick   (tick_en),
        .ld     (cnt_ld),
        .ld_val (cnt_ld_val),
        .cnt    (cnt_q)
    );

    evt_irq_status #(.NCH(NCH)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (ch_irq_set),
        .clr_req (clr_req),
        .level   (irq_level),
        .clr_hit (irq_clr)
    );

    // Read source selection and half extraction.
    always_comb begin
        case (dec_rg)
            RG_CAP:  rd_raw = CAP_WORD;
            RG_CFG:  rd_raw = cfg_q;
            RG_STS:  rd_raw = 64'(irq_level);
            RG_CNT:  rd_raw = {32'h0, cnt_q};
            RG_CHAN: rd_raw = ch_rdata;
            default: rd_raw = '0;
        endcase
        if (!dec_ok)       rd_word = '0;
        else if (dec_hi)   rd_word = {32'h0, rd_raw[63:32]};
        else if (dec_wide) rd_word = rd_raw;
        else               rd_word = {32'h0, rd_raw[31:0]};
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_word;
    end

    assign cnt_en   = cfg_q[CFG_EN_BIT];
    assign cnt_val  = cnt_q;
    assign ch_wr    = wr_go ? dec_ch : '0;
    assign ch_rd    = rd_go ? dec_ch : '0;
    assign ch_wdata = wal;
    assign ch_wmask = wmask;

endmodule

// File: rtl/evt_regfront_chk.sv
// Checker for evt_regfront, bound to every instance. Watches port-level
// rules of the counter, the status word and the channel strobes.
module evt_regfront_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_stb,
    input logic           rd_stb,
    input logic [3:0]     acc_size,
    input logic [63:0]    rdata,
    input logic           tick_en,
    input logic           cnt_en,
    input logic [31:0]    cnt_val,
    input logic           cnt_restart,
    input logic [NCH-1:0] ch_wr,
    input logic [NCH-1:0] ch_rd,
    input logic [NCH-1:0] ch_irq_set,
    input logic [NCH-1:0] irq_level,
    input logic [NCH-1:0] irq_clr
);
    assert_badsize_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && acc_size != 4'd4 && acc_size != 4'd8) |=> (rdata == 64'd0));

    assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && tick_en && !wr_stb) |=> (cnt_val == $past(cnt_val) + 32'd1));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_stb) |=> $stable(cnt_val));

    assert_restart_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_restart |-> cnt_en);

    assert_set_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_irq_set) |=> ((irq_level & $past(ch_irq_set)) == $past(ch_irq_set)));

    assert_clr_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_clr) |=> ((irq_level & $past(irq_clr) & ~$past(ch_irq_set)) == '0));

    assert_wr_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr) && $onehot0(ch_rd));

endmodule

bind evt_regfront evt_regfront_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .rd_stb      (rd_stb),
    .acc_size    (acc_size),
    .rdata       (rdata),
    .tick_en     (tick_en),
    .cnt_en      (cnt_en),
    .cnt_val     (cnt_val),
    .cnt_restart (cnt_restart),
    .ch_wr       (ch_wr),
    .ch_rd       (ch_rd),
    .ch_irq_set  (ch_irq_set),
    .irq_level   (irq_level),
    .irq_clr     (irq_clr)
);

// File: tb/sim_evt_regfront.sv
// Directed bench for evt_regfront: one task per scenario, inputs driven on
// the falling edge, outputs sampled away from the rising edge.
module sim_evt_regfront;
    localparam int AW  = 12;
    localparam int NCH = 8;
    localparam logic [63:0] CAP_EXP = 64'h05F5E100_A5C30701;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_stb = 1'b0, rd_stb = 1'b0, tick_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [3:0]     acc_size = 4'd8;
    logic [63:0]    wdata = '0, ch_rdata = 64'hCAFE0000_BEEF1111;
    logic [NCH-1:0] ch_irq_set = '0;
    logic [63:0]    rdata, ch_wdata, ch_wmask;
    logic           cnt_en, cnt_restart;
    logic [31:0]    cnt_val;
    logic [NCH-1:0] ch_wr, ch_rd, irq_level, irq_clr;
    logic [1:0]     ch_reg;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [NCH-1:0] cap_chwr, cap_chrd, cap_clr;
    logic [1:0]     cap_reg;
    logic [63:0]    cap_wd, cap_wm, rd_res;

    always #4 clk = ~clk;

    evt_regfront #(.AW(AW), .NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(addr), .acc_size(acc_size), .wdata(wdata), .rdata(rdata),
        .tick_en(tick_en), .cnt_en(cnt_en), .cnt_val(cnt_val),
        .cnt_restart(cnt_restart), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .ch_reg(ch_reg), .ch_wdata(ch_wdata), .ch_wmask(ch_wmask),
        .ch_rdata(ch_rdata), .ch_irq_set(ch_irq_set),
        .irq_level(irq_level), .irq_clr(irq_clr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
        end
    endtask

    // Write; captures same-cycle outputs before the rising edge.
    task automatic wr(input logic [AW-1:0] a, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        addr = a; acc_size = sz; wdata = d; wr_stb = 1'b1;
        #2;
        cap_chwr = ch_wr; cap_clr = irq_clr; cap_reg = ch_reg;
        cap_wd = ch_wdata; cap_wm = ch_wmask;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [3:0] sz);
        @(negedge clk);
        addr = a; acc_size = sz; rd_stb = 1'b1;
        #2;
        cap_chrd = ch_rd;
        @(negedge clk);
        rd_stb = 1'b0;
        rd_res = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 cfg", 64'(cnt_en), 0);
        chk("R11 counter", 64'(cnt_val), 0);
        chk("R11 status", 64'(irq_level), 0);
        chk("R11 rdata", rdata, 0);
        chk("R11 restart", 64'(cnt_restart), 0);
    endtask

    task automatic t_capability;
        rd(12'h000, 4'd8); chk("R3 cap 8-byte", rd_res, CAP_EXP);
        rd(12'h004, 4'd4); chk("R3 R2 cap upper half", rd_res, 64'h05F5E100);
        rd(12'h000, 4'd4); chk("R2 cap lower half zero-extended", rd_res, 64'hA5C30701);
        wr(12'h000, 4'd8, 64'h0);
        rd(12'h000, 4'd8); chk("R3 cap write ignored", rd_res, CAP_EXP);
    endtask

    task automatic t_size_align;
        wr(12'h010, 4'd2, 64'h5);
        rd(12'h010, 4'd8); chk("R1 2-byte write dropped", rd_res, 0);
        wr(12'h014, 4'd8, 64'h5);
        rd(12'h010, 4'd8); chk("R1 misaligned write dropped", rd_res, 0);
        rd(12'h000, 4'd2); chk("R1 2-byte read zero", rd_res, 0);
        rd(12'h004, 4'd8); chk("R1 misaligned read zero", rd_res, 0);
        wr(12'h102, 4'd4, 64'h1);
        chk("R1 misaligned channel write no strobe", 64'(cap_chwr), 0);
    endtask

    task automatic t_config;
        wr(12'h010, 4'd8, 64'h0000_0000_0000_00F2);
        rd(12'h010, 4'd8); chk("R4 legacy bit reads zero", rd_res, 64'hF0);
        wr(12'h014, 4'd4, 64'h0000_ABCD);
        rd(12'h010, 4'd8); chk("R2 upper-half config write", rd_res, 64'h0000ABCD_000000F0);
        wr(12'h010, 4'd8, 64'h0);
    endtask

    task automatic t_counter;
        wr(12'h0F0, 4'd8, 64'hFFFFFFFF_11223344);
        chk("R7 no restart while disabled", 64'(cnt_restart), 0);
        chk("R7 8-byte write truncates", 64'(cnt_val), 64'h11223344);
        ticks(4);
        chk("R5 frozen while disabled", 64'(cnt_val), 64'h11223344);
        wr(12'h010, 4'd8, 64'h1);
        chk("R6 restart on enable", 64'(cnt_restart), 1);
        @(negedge clk);
        chk("R6 restart lasts one cycle", 64'(cnt_restart), 0);
        ticks(5);
        rd(12'h0F0, 4'd8); chk("R5 counts ticks", rd_res, 64'h11223349);
        wr(12'h010, 4'd8, 64'h1);
        chk("R6 no restart on same value", 64'(cnt_restart), 0);
        wr(12'h0F4, 4'd4, 64'hDEAD);
        chk("R7 upper-half write keeps counter", 64'(cnt_val), 64'h11223349);
        chk("R7 restart while enabled", 64'(cnt_restart), 1);
        rd(12'h0F4, 4'd4); chk("R7 counter upper half zero", rd_res, 0);
        wr(12'h0F0, 4'd4, 64'h55);
        chk("R7 lower-half write", 64'(cnt_val), 64'h55);
        wr(12'h010, 4'd8, 64'h0);
        chk("R6 no restart on disable", 64'(cnt_restart), 0);
        ticks(3);
        chk("R5 frozen after disable", 64'(cnt_val), 64'h55);
    endtask

    task automatic t_status;
        @(negedge clk); ch_irq_set = 8'hA5;
        @(negedge clk); ch_irq_set = 8'h00;
        rd(12'h020, 4'd8); chk("R8 set bits read back", rd_res, 64'hA5);
        wr(12'h020, 4'd4, 64'h0F);
        chk("R8 irq_clr shows set-and-written bits", 64'(cap_clr), 64'h05);
        chk("R8 status after clear", 64'(irq_level), 64'hA0);
        wr(12'h024, 4'd4, 64'hFF);
        chk("R8 R2 upper-half write clears nothing", 64'(irq_level), 64'hA0);
        ch_irq_set = 8'h80;
        wr(12'h020, 4'd8, 64'h80);
        ch_irq_set = 8'h00;
        chk("R8 set beats clear", 64'(irq_level), 64'hA0);
        wr(12'h020, 4'd8, 64'hFF);
        chk("R8 full clear", 64'(irq_level), 0);
    endtask

    task automatic t_channel;
        wr(12'h168, 4'd4, 64'h1234);
        chk("R10 write strobe ch3", 64'(cap_chwr), 64'h08);
        chk("R10 comparator select", 64'(cap_reg), 1);
        chk("R10 lower data", cap_wd[31:0], 64'h1234);
        chk("R10 lower mask", cap_wm, 64'h00000000_FFFFFFFF);
        wr(12'h16C, 4'd4, 64'h1234);
        chk("R10 R2 upper data", cap_wd, 64'h00001234_00000000);
        chk("R10 upper mask", cap_wm, 64'hFFFFFFFF_00000000);
        wr(12'h1F0, 4'd8, 64'h1);
        chk("R10 message reg ch7", 64'(cap_chwr), 64'h80);
        chk("R10 message select", 64'(cap_reg), 2);
        rd(12'h150, 4'd8); chk("R10 channel read", rd_res, 64'hCAFE0000_BEEF1111);
        chk("R10 read strobe ch2", 64'(cap_chrd), 64'h04);
        rd(12'h154, 4'd4); chk("R10 channel upper half", rd_res, 64'hCAFE0000);
    endtask

    task automatic t_unmapped;
        rd(12'h200, 4'd8); chk("R9 channel index 8 unmapped", rd_res, 0);
        chk("R9 no strobe beyond channels", 64'(cap_chrd), 0);
        rd(12'h118, 4'd8); chk("R9 sub-offset 0x18 unmapped", rd_res, 0);
        rd(12'h030, 4'd8); chk("R9 gap unmapped", rd_res, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capability();
        t_size_align();
        t_config();
        t_counter();
        t_status();
        t_channel();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule